// File: doc/BRIEF.md
# Sequential Stream Buffer Prefetcher

This block sits between a cache and the next memory level and serves the cache's misses. When a miss arrives, the block compares the missing block address against the oldest entry of each of several small FIFO stream buffers. If the oldest entry of a buffer holds that block, the block's data goes straight back to the cache. That buffer then drops its oldest entry and queues a fetch for the block that follows its newest entry. If no buffer matches, a demand request goes to memory. The least recently used buffer is also cleared and restarted on the blocks that follow the missing one.

Prefetched blocks never enter the cache directly. They wait in the buffers until a later miss asks for them. The buffers are independent, so interleaved sequential streams (for example, one for instructions and several for data arrays) can each keep their own run of blocks ready. All memory traffic uses one request port. Demand fetches there always win over prefetches, so prefetching only uses bandwidth that the demand path leaves idle.

The cache presents one miss at a time and waits for its answer. Memory answers each request with the block address and the prefetch flag of that request, in any order.

Top module: `stream_prefetcher`

## Requirements
- R1: After reset, `resp_valid` and `mem_req_valid` are low and `miss_ready` is high.
- R2: A miss whose block heads no buffer produces exactly one memory request with `mem_req_pf`=0 for that block. The response returns the memory data with `resp_hit`=0.
- R3: That miss restarts one buffer on the DEPTH blocks that follow the missing block. Their prefetch requests (`mem_req_pf`=1) are issued in ascending address order, after the demand request.
- R4: A miss whose block sits, already filled, at the head of a buffer is answered in the cycle after acceptance. The answer has `resp_hit`=1 and that block's data, and no demand request is made.
- R5: After a head hit, the buffer issues a prefetch for the block one past its newest entry.
- R6: Only buffer heads are compared. A block held deeper in a buffer is handled as a miss, and the buffer that holds it keeps its head.
- R7: Each of NBUF buffers follows its own sequential stream, so interleaved misses on NBUF streams all hit.
- R8: On a miss that matches no head, the buffer touched (hit or allocated) least recently is the one replaced.
- R9: While a demand request is outstanding, the memory port presents it (`mem_req_pf`=0) even if prefetches are pending.
- R10: A demand request that is not accepted keeps its address on the port until `mem_req_ready` is high.
- R11: `resp_valid` is a one-cycle pulse, and `miss_ready` stays low from acceptance until the cycle after the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_valid | input | 1 | Cache presents a miss |
| miss_blk | input | ABITS | Block address of the miss |
| miss_ready | output | 1 | Block can accept a miss this cycle |
| resp_valid | output | 1 | Answer to the accepted miss is present |
| resp_hit | output | 1 | 1: answer came from a stream buffer; 0: from memory |
| resp_data | output | DBITS | Block data |
| mem_req_valid | output | 1 | Request to memory |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_blk | output | ABITS | Requested block address |
| mem_req_pf | output | 1 | 1: prefetch, 0: demand |
| mem_rsp_valid | input | 1 | Memory returns a block |
| mem_rsp_pf | input | 1 | Prefetch flag echoed from the request |
| mem_rsp_blk | input | ABITS | Block address echoed from the request |
| mem_rsp_data | input | DBITS | Returned data |

## Verification
The hardest state to reach is a demand miss that collides with prefetch work still waiting for the port. Normally memory takes prefetches as fast as they are issued, so no contention arises. The bench first fills a stream and then holds the memory port not ready. A head hit then leaves a visible refill prefetch on the port, and a non-matching miss is issued while that prefetch waits. The replacement order is observed only through later hits and misses. The bench therefore builds four streams, touches them in a known order, evicts one and probes which streams survive.

// File: rtl/spf_pkg.sv
// Shared types for the stream buffer prefetcher.
// Assumes: nothing beyond IEEE 1800-2017.
package spf_pkg;
    // Life of one buffer entry: unused, waiting to be requested, in flight, holding data.
    typedef enum logic [1:0] {ENT_EMPTY, ENT_PEND, ENT_ISSUED, ENT_FULL} ent_st_e;
    // Demand path control: idle, presenting a demand request, waiting for its data.
    typedef enum logic [1:0] {CTL_IDLE, CTL_REQ, CTL_WAIT} ctl_e;
endpackage

// File: rtl/sbuf_fifo.sv
// One stream buffer: a circular FIFO of DEPTH consecutive block addresses.
// Reports a hit when its filled head equals the lookup address. It offers the
// oldest not-yet-requested entry as a prefetch and captures prefetch data by
// address. Assumes DEPTH is a power of two and that alloc, pop and gnt are never
// aimed at the same entry (pop needs a FULL head, gnt a PEND entry).
module sbuf_fifo
    import spf_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int ABITS = 16,
    parameter int DBITS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc,
    input  logic [ABITS-1:0] alloc_blk,
    input  logic [ABITS-1:0] lk_blk,
    input  logic             pop,
    input  logic             gnt,
    input  logic             rsp_valid,
    input  logic             rsp_pf,
    input  logic [ABITS-1:0] rsp_blk,
    input  logic [DBITS-1:0] rsp_data,
    output logic             head_hit,
    output logic [DBITS-1:0] head_data,
    output logic             pf_valid,
    output logic [ABITS-1:0] pf_blk
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [ABITS-1:0] tag  [DEPTH];
    ent_st_e          st   [DEPTH];
    logic [DBITS-1:0] data [DEPTH];
    logic [PW-1:0]    head;
    logic [ABITS-1:0] nxt_blk;
    logic [PW-1:0]    pf_idx;

    // Head compare: only the oldest entry can satisfy a miss.
    always_comb begin
        head_hit  = (st[head] == ENT_FULL) && (tag[head] == lk_blk);
        head_data = data[head];
    end

    // Prefetch pick: the pending entry closest to the head.
    always_comb begin
        pf_valid = 1'b0;
        pf_idx   = head;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            if (st[head + PW'(k)] == ENT_PEND) begin
                pf_valid = 1'b1;
                pf_idx   = head + PW'(k);
            end
        end
        pf_blk = tag[pf_idx];
    end

    // Entry state, tags and pointers: allocation overrides everything else.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                st[i]  <= ENT_EMPTY;
                tag[i] <= '0;
            end
            head    <= '0;
            nxt_blk <= '0;
        end else if (alloc) begin
            for (int i = 0; i < DEPTH; i++) begin
                st[i]  <= ENT_PEND;
                tag[i] <= alloc_blk + ABITS'(i);
            end
            head    <= '0;
            nxt_blk <= alloc_blk + ABITS'(DEPTH);
        end else begin
            if (gnt) st[pf_idx] <= ENT_ISSUED;
            for (int i = 0; i < DEPTH; i++) begin
                if (rsp_valid && rsp_pf && st[i] == ENT_ISSUED && tag[i] == rsp_blk)
                    st[i] <= ENT_FULL;
            end
            if (pop) begin
                st[head]  <= ENT_PEND;
                tag[head] <= nxt_blk;
                head      <= head + 1'b1;
                nxt_blk   <= nxt_blk + 1'b1;
            end
        end
    end

    // Data capture for prefetch responses addressed to an in-flight entry.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (rsp_valid && rsp_pf && st[i] == ENT_ISSUED && tag[i] == rsp_blk)
                data[i] <= rsp_data;
        end
    end

    a_r4_pop_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (st[head] == ENT_FULL && tag[head] == lk_blk));
    a_r3_grant_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt && !alloc) |=> (st[$past(pf_idx)] == ENT_ISSUED || st[$past(pf_idx)] == ENT_FULL));
endmodule

// File: rtl/sbuf_lru.sv
// Recency ranking of NBUF stream buffers. Rank 0 is the most recently
// touched and rank NBUF-1 is the replacement victim. Assumes at most one
// touch per cycle; ranks start as the buffer index so they are distinct.
module sbuf_lru #(
    parameter int NBUF = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            touch,
    input  logic [$clog2(NBUF)-1:0] touch_idx,
    output logic [NBUF-1:0] victim_oh,
    output logic [$clog2(NBUF)-1:0] victim_idx
);
    localparam int IW = $clog2(NBUF);

    logic [IW-1:0] rank [NBUF];

    // Rank update: touched buffer to 0, those more recent than it age by one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NBUF; i++) rank[i] <= IW'(i);
        end else if (touch) begin
            for (int i = 0; i < NBUF; i++) begin
                if (IW'(i) == touch_idx)           rank[i] <= '0;
                else if (rank[i] < rank[touch_idx]) rank[i] <= rank[i] + 1'b1;
            end
        end
    end

    // Victim decode: the buffer holding the oldest rank.
    always_comb begin
        victim_idx = '0;
        for (int i = 0; i < NBUF; i++) begin
            victim_oh[i] = (rank[i] == IW'(NBUF - 1));
            if (victim_oh[i]) victim_idx = IW'(i);
        end
    end

    a_r8_single_victim: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(victim_oh));
endmodule

// File: rtl/mem_arb.sv
// Memory port arbiter: the demand request always wins over a prefetch.
// Assumes the demand source holds its request until granted.
module mem_arb #(
    parameter int ABITS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dem_valid,
    input  logic [ABITS-1:0] dem_blk,
    input  logic             pf_valid,
    input  logic [ABITS-1:0] pf_blk,
    input  logic             ready,
    output logic             req_valid,
    output logic [ABITS-1:0] req_blk,
    output logic             req_pf,
    output logic             dem_gnt,
    output logic             pf_gnt
);
    // Fixed priority selection toward the single memory port.
    always_comb begin
        req_valid = dem_valid || pf_valid;
        req_pf    = !dem_valid;
        req_blk   = dem_valid ? dem_blk : pf_blk;
        dem_gnt   = dem_valid && ready;
        pf_gnt    = !dem_valid && pf_valid && ready;
    end

    a_r9_demand_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (dem_valid && pf_valid) |-> (!pf_gnt && req_blk == dem_blk));
endmodule

// File: rtl/stream_prefetcher.sv
// Stream buffer prefetcher top. Accepts one cache miss at a time and looks it
// up against every buffer head. A hit is answered from the buffer; a miss is
// fetched from memory while the LRU buffer restarts after the missing block.
// Assumes memory echoes the block address and prefetch flag of each request.
module stream_prefetcher
    import spf_pkg::*;
#(
    parameter int NBUF  = 4,
    parameter int DEPTH = 4,
    parameter int ABITS = 16,
    parameter int DBITS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             miss_valid,
    input  logic [ABITS-1:0] miss_blk,
    output logic             miss_ready,
    output logic             resp_valid,
    output logic             resp_hit,
    output logic [DBITS-1:0] resp_data,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [ABITS-1:0] mem_req_blk,
    output logic             mem_req_pf,
    input  logic             mem_rsp_valid,
    input  logic             mem_rsp_pf,
    input  logic [ABITS-1:0] mem_rsp_blk,
    input  logic [DBITS-1:0] mem_rsp_data
);
    localparam int IW = $clog2(NBUF);

    ctl_e             state;
    logic [ABITS-1:0] dem_blk;
    logic             accept, any_hit, pf_any, dem_gnt, pf_gnt;
    logic [IW-1:0]    hit_idx, pf_sel, victim_idx, touch_idx;
    logic [NBUF-1:0]  hit_v, pf_v, victim_oh, pop_v, alloc_v, gnt_v;
    logic [DBITS-1:0] hdata [NBUF];
    logic [ABITS-1:0] pblk  [NBUF];
    logic [ABITS-1:0] pf_blk_sel;

    for (genvar g = 0; g < NBUF; g++) begin : g_buf
        sbuf_fifo #(.DEPTH(DEPTH), .ABITS(ABITS), .DBITS(DBITS)) u_buf (
            .clk(clk), .rst_n(rst_n),
            .alloc(alloc_v[g]), .alloc_blk(miss_blk + 1'b1), .lk_blk(miss_blk),
            .pop(pop_v[g]), .gnt(gnt_v[g]),
            .rsp_valid(mem_rsp_valid), .rsp_pf(mem_rsp_pf),
            .rsp_blk(mem_rsp_blk), .rsp_data(mem_rsp_data),
            .head_hit(hit_v[g]), .head_data(hdata[g]),
            .pf_valid(pf_v[g]), .pf_blk(pblk[g])
        );
    end

    sbuf_lru #(.NBUF(NBUF)) u_lru (
        .clk(clk), .rst_n(rst_n), .touch(accept), .touch_idx(touch_idx),
        .victim_oh(victim_oh), .victim_idx(victim_idx)
    );

    mem_arb #(.ABITS(ABITS)) u_arb (
        .clk(clk), .rst_n(rst_n),
        .dem_valid(state == CTL_REQ), .dem_blk(dem_blk),
        .pf_valid(pf_any), .pf_blk(pf_blk_sel), .ready(mem_req_ready),
        .req_valid(mem_req_valid), .req_blk(mem_req_blk), .req_pf(mem_req_pf),
        .dem_gnt(dem_gnt), .pf_gnt(pf_gnt)
    );

    // Lookup and steering: lowest-index head hit, lowest-index pending prefetch.
    always_comb begin
        miss_ready = (state == CTL_IDLE) && !resp_valid;
        accept     = miss_valid && miss_ready;
        any_hit    = 1'b0;
        hit_idx    = '0;
        pf_any     = 1'b0;
        pf_sel     = '0;
        for (int i = NBUF - 1; i >= 0; i--) begin
            if (hit_v[i]) begin any_hit = 1'b1; hit_idx = IW'(i); end
            if (pf_v[i])  begin pf_any  = 1'b1; pf_sel  = IW'(i); end
        end
        pf_blk_sel = pblk[pf_sel];
        touch_idx  = any_hit ? hit_idx : victim_idx;
        for (int i = 0; i < NBUF; i++) begin
            pop_v[i]   = accept && any_hit && (hit_idx == IW'(i));
            alloc_v[i] = accept && !any_hit && victim_oh[i];
            gnt_v[i]   = pf_gnt && (pf_sel == IW'(i));
        end
    end

    // Demand path sequencing: request, then wait for the matching data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= CTL_IDLE;
            dem_blk <= '0;
        end else begin
            case (state)
                CTL_IDLE: if (accept && !any_hit) begin
                    state   <= CTL_REQ;
                    dem_blk <= miss_blk;
                end
                CTL_REQ:  if (dem_gnt) state <= CTL_WAIT;
                CTL_WAIT: if (mem_rsp_valid && !mem_rsp_pf && mem_rsp_blk == dem_blk)
                    state <= CTL_IDLE;
                default:  state <= CTL_IDLE;
            endcase
        end
    end

    // Response register: one-cycle answer from a buffer head or from memory.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_hit   <= 1'b0;
            resp_data  <= '0;
        end else begin
            resp_valid <= 1'b0;
            if (accept && any_hit) begin
                resp_valid <= 1'b1;
                resp_hit   <= 1'b1;
                resp_data  <= hdata[hit_idx];
            end else if (state == CTL_WAIT && mem_rsp_valid && !mem_rsp_pf
                         && mem_rsp_blk == dem_blk) begin
                resp_valid <= 1'b1;
                resp_hit   <= 1'b0;
                resp_data  <= mem_rsp_data;
            end
        end
    end

    a_r10_demand_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_pf && !mem_req_ready)
        |=> (mem_req_valid && !mem_req_pf && $stable(mem_req_blk)));
    a_r11_resp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);
    a_r4_hit_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_hit) |-> $past(miss_valid && miss_ready));
    a_r11_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_pf) |-> !miss_ready);
endmodule

// File: tb/sim_stream_prefetcher.sv
module sim_stream_prefetcher;
    localparam int CLK_P = 10;
    localparam int AB = 16;
    localparam int DB = 32;
    localparam int LAT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic miss_valid = 1'b0;
    logic [AB-1:0] miss_blk = '0;
    logic miss_ready, resp_valid, resp_hit;
    logic [DB-1:0] resp_data;
    logic mem_req_valid, mem_req_pf;
    logic mem_req_ready = 1'b0;
    logic [AB-1:0] mem_req_blk;
    logic mem_rsp_valid = 1'b0, mem_rsp_pf = 1'b0;
    logic [AB-1:0] mem_rsp_blk = '0;
    logic [DB-1:0] mem_rsp_data = '0;

    int checks = 0, errors = 0;
    bit done = 1'b0;
    bit stall = 1'b0;
    int cyc = 0, wr = 0, rd = 0, logn = 0, dem_cnt = 0;
    logic [AB-1:0] q_blk [256];
    logic          q_pf  [256];
    int            q_due [256];
    logic [AB-1:0] log_blk [256];
    logic          log_pf  [256];

    stream_prefetcher u0 (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_blk(miss_blk),
        .miss_ready(miss_ready), .resp_valid(resp_valid), .resp_hit(resp_hit),
        .resp_data(resp_data), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_blk(mem_req_blk),
        .mem_req_pf(mem_req_pf), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_pf(mem_rsp_pf), .mem_rsp_blk(mem_rsp_blk),
        .mem_rsp_data(mem_rsp_data)
    );

    always #(CLK_P / 2) clk = ~clk;

    function automatic logic [DB-1:0] blk_data(input logic [AB-1:0] b);
        return {b, b ^ 16'hA5C3};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Memory model: fixed latency, in-order responses, echoes address and flag.
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (mem_rsp_valid) rd = (rd + 1) & 255;
            if (rd != wr && q_due[rd] <= cyc) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_blk   = q_blk[rd];
                mem_rsp_pf    = q_pf[rd];
                mem_rsp_data  = blk_data(q_blk[rd]);
            end else begin
                mem_rsp_valid = 1'b0;
            end
            mem_req_ready = !stall;
            if (rst_n && mem_req_valid && !stall) begin
                q_blk[wr] = mem_req_blk;
                q_pf[wr]  = mem_req_pf;
                q_due[wr] = cyc + LAT;
                wr = (wr + 1) & 255;
                log_blk[logn & 255] = mem_req_blk;
                log_pf[logn & 255]  = mem_req_pf;
                logn++;
                if (!mem_req_pf) dem_cnt++;
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        miss_valid = 1'b0;
        stall = 1'b0;
        repeat (3) @(negedge clk);
        wr = 0; rd = 0; logn = 0; dem_cnt = 0;
        mem_rsp_valid = 1'b0;
        rst_n = 1'b1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Present one miss, wait for its answer and check hit flag and data.
    task automatic do_miss(input logic [AB-1:0] b, input bit exp_hit, input string req);
        int n = 0;
        @(negedge clk);
        miss_valid = 1'b1;
        miss_blk = b;
        while (!miss_ready) @(negedge clk);
        @(negedge clk);
        miss_valid = 1'b0;
        while (!resp_valid && n < 200) begin @(negedge clk); n++; end
        check(resp_valid == 1'b1, req, 32'(resp_valid), 32'h1);
        check(resp_hit == exp_hit, req, 32'(resp_hit), 32'(exp_hit));
        check(resp_data == blk_data(b), req, resp_data, blk_data(b));
        check(miss_ready == 1'b0, "R11", 32'(miss_ready), 32'h0);
    endtask

    initial begin
        logic [AB-1:0] a, q;
        logic [AB-1:0] bs [4];
        bs[0] = 16'h1000; bs[1] = 16'h2000; bs[2] = 16'h3000; bs[3] = 16'h4000;

        // R1: reset state
        do_reset();
        check(resp_valid == 1'b0, "R1", 32'(resp_valid), 32'h0);
        check(mem_req_valid == 1'b0, "R1", 32'(mem_req_valid), 32'h0);
        check(miss_ready == 1'b1, "R1", 32'(miss_ready), 32'h1);

        // R2/R3: cold miss, then the next DEPTH blocks prefetched in order
        a = 16'h0100;
        do_miss(a, 1'b0, "R2");
        idle(20);
        check(log_blk[0] == a && log_pf[0] == 1'b0, "R2", 32'(log_blk[0]), 32'(a));
        for (int k = 1; k <= 4; k++)
            check(log_blk[k] == a + AB'(k) && log_pf[k] == 1'b1, "R3",
                  32'(log_blk[k]), 32'(a + AB'(k)));
        // R4/R5: sequential head hits and tail refills
        for (int k = 1; k <= 8; k++) begin
            do_miss(a + AB'(k), 1'b1, "R4");
            idle(10);
        end
        check(dem_cnt == 1, "R4", 32'(dem_cnt), 32'h1);
        check(logn == 13, "R5", 32'(logn), 32'd13);
        for (int k = 1; k <= 8; k++)
            check(log_blk[4 + k] == a + AB'(4 + k) && log_pf[4 + k] == 1'b1, "R5",
                  32'(log_blk[4 + k]), 32'(a + AB'(4 + k)));
        // R6: second entry of a buffer is not a hit; the head still is
        do_miss(a + 16'd10, 1'b0, "R6");
        idle(20);
        do_miss(a + 16'd9, 1'b1, "R6");

        // R7/R8: four interleaved streams, then replacement of the oldest
        do_reset();
        for (int s = 0; s < 4; s++) begin
            do_miss(bs[s], 1'b0, "R7");
            idle(20);
        end
        for (int r = 1; r <= 2; r++)
            for (int s = 0; s < 4; s++) begin
                do_miss(bs[s] + AB'(r), 1'b1, "R7");
                idle(8);
            end
        do_miss(16'h5000, 1'b0, "R8");
        idle(20);
        do_miss(bs[1] + 16'd3, 1'b1, "R8");
        do_miss(bs[3] + 16'd3, 1'b1, "R8");
        do_miss(bs[0] + 16'd3, 1'b0, "R8");

        // R9/R10: demand overtakes a waiting prefetch on a stalled port
        do_reset();
        a = 16'h0700;
        do_miss(a, 1'b0, "R9");
        idle(20);
        stall = 1'b1;
        do_miss(a + 16'd1, 1'b1, "R9");
        idle(1);
        check(mem_req_valid && mem_req_pf && mem_req_blk == a + 16'd5, "R5",
              32'(mem_req_blk), 32'(a + 16'd5));
        q = 16'h0900;
        @(negedge clk);
        miss_valid = 1'b1;
        miss_blk = q;
        @(negedge clk);
        miss_valid = 1'b0;
        for (int k = 0; k < 3; k++) begin
            check(mem_req_valid && !mem_req_pf, "R9", 32'(mem_req_pf), 32'h0);
            check(mem_req_blk == q, "R10", 32'(mem_req_blk), 32'(q));
            check(miss_ready == 1'b0, "R11", 32'(miss_ready), 32'h0);
            @(negedge clk);
        end
        stall = 1'b0;
        begin
            int n = 0;
            while (!resp_valid && n < 100) begin @(negedge clk); n++; end
        end
        check(resp_valid && !resp_hit, "R9", 32'(resp_hit), 32'h0);
        check(resp_data == blk_data(q), "R9", resp_data, blk_data(q));
        @(negedge clk);
        check(resp_valid == 1'b0, "R11", 32'(resp_valid), 32'h0);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule